// File: doc/BRIEF.md
# SPI FIFO Interrupt Status Unit

This unit holds the interrupt bookkeeping for an SPI controller that moves bytes through a transmit FIFO and a receive FIFO. It watches the FIFO occupancy counts, the two full flags and three single-cycle event pulses. From these it keeps a seven-bit status word. Three of the bits latch events: transmit underflow, receive overflow and mode fail. The other four are recomputed every cycle from FIFO state against two programmable thresholds. An interrupt enable mask gates the status word onto one registered, level-sensitive interrupt line.

Software reaches the unit through a single-cycle register port. `reg_rdata` always reflects the word selected by `reg_addr`. Asserting `reg_rd` for one cycle marks that word as consumed, and for the status word this clears it. Every access finishes in the cycle it is issued. There is no stall and no back-pressure, so the port carries no valid/ready pair. The FIFOs and shift logic sit outside the unit. A linear-read input from the controller freezes all hardware-driven status updates while it is high.

Top module: `spi_irq_status_unit`

## Requirements
- R1: Reset state: the status word reads 0, the mask reads 0, both thresholds read 1 and `irq` is 0.
- R2: Status bit map: bit6 transmit underflow, bit5 receive FIFO full, bit4 receive level, bit3 transmit FIFO full, bit2 transmit low, bit1 mode fail, bit0 receive overflow. The level bits 5, 4, 3 and 2 follow FIFO state one clock after it changes, and bits 31..7 read 0.
- R3: Bit4 is 1 when `rx_count` >= receive threshold. Bit2 is 1 when `tx_count` < transmit threshold (strict).
- R4: Bits 6, 1 and 0 set on their event pulse and stay set until software clears them.
- R5: A read (`reg_rd`) of the status word at address 0 returns its current value and clears all seven bits at that clock edge. Level bits reappear one clock later if their condition still holds.
- R6: A write to address 0 clears each status bit written as 1 and leaves the others unchanged.
- R7: A write to address 1 ORs the low seven data bits into the mask. A write to address 2 clears the mask bits written as 1. A write to the mask at address 3 has no effect. Addresses 1 and 2 read 0.
- R8: `irq` is the OR over the seven bits of (mask AND status). It is registered and changes on the same edge as the status and mask words.
- R9: While `lin_mode` is 1, event pulses and FIFO state are ignored and `irq` holds its value. Software clears of the status word still act.
- R10: When an event pulse and a software clear of the same bit fall in one cycle, the bit ends up set.
- R11: The transmit threshold is at address 4 and the receive threshold at address 5. Both are writable and readable, and a new value takes effect on the level bits from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read-consume strobe |
| reg_addr | input | 3 | Word select: 0 status, 1 enable-set, 2 enable-clear, 3 mask, 4 transmit threshold, 5 receive threshold |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Selected word, combinational from `reg_addr` |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| tx_full | input | 1 | Transmit FIFO full |
| rx_full | input | 1 | Receive FIFO full |
| ev_tx_underflow | input | 1 | Transmit underflow pulse |
| ev_rx_overflow | input | 1 | Receive overflow pulse |
| ev_mode_fail | input | 1 | Mode fail pulse |
| lin_mode | input | 1 | Linear-read mode, freezes status updates |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the unit with a 4-bit count width and the default 32-bit data word. The narrow count width keeps every threshold and occupancy value within a few writes. The threshold boundaries (count equal to threshold, and one below it) are driven on both the receive and the transmit side. The 32-bit word shows that the bits above the seven status bits read as zero.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int unsigned NUM_BITS = 7;
  localparam int unsigned SEL_W    = 3;

  localparam int unsigned BIT_TX_UNDER  = 6;
  localparam int unsigned BIT_RX_FULL   = 5;
  localparam int unsigned BIT_RX_LVL    = 4;
  localparam int unsigned BIT_TX_FULL   = 3;
  localparam int unsigned BIT_TX_LOW    = 2;
  localparam int unsigned BIT_MODE_FAIL = 1;
  localparam int unsigned BIT_RX_OVER   = 0;

  // event-latched bits; all others are recomputed from FIFO state
  localparam logic [NUM_BITS-1:0] STICKY_MASK = 7'b100_0011;

  typedef logic [NUM_BITS-1:0] irq_vec_t;

  typedef enum logic [SEL_W-1:0] {
    SEL_STATUS = 3'd0,
    SEL_SET_EN = 3'd1,
    SEL_CLR_EN = 3'd2,
    SEL_MASK   = 3'd3,
    SEL_TX_THR = 3'd4,
    SEL_RX_THR = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/spi_irq_level_eval.sv
module spi_irq_level_eval
  import spi_irq_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic [CNT_W-1:0] tx_count,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             tx_full,
  input  logic             rx_full,
  input  logic [CNT_W-1:0] tx_thr,
  input  logic [CNT_W-1:0] rx_thr,
  output irq_vec_t         level
);
  always_comb begin
    level                = '0;
    level[BIT_RX_FULL]   = rx_full;
    level[BIT_RX_LVL]    = (rx_count >= rx_thr);
    level[BIT_TX_FULL]   = tx_full;
    level[BIT_TX_LOW]    = (tx_count < tx_thr);
  end
endmodule

// File: rtl/spi_irq_status_bank.sv
module spi_irq_status_bank
  import spi_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     freeze,
  input  irq_vec_t level,
  input  irq_vec_t events,
  input  irq_vec_t clr,
  output irq_vec_t status_q,
  output irq_vec_t status_d
);
  for (genvar i = 0; i < NUM_BITS; i++) begin : g_bit
    if (STICKY_MASK[i]) begin : g_sticky
      // a fresh event outranks a clear in the same cycle
      always_comb begin
        if (!freeze && events[i]) status_d[i] = 1'b1;
        else if (clr[i])          status_d[i] = 1'b0;
        else                      status_d[i] = status_q[i];
      end
    end else begin : g_level
      always_comb begin
        if (clr[i])      status_d[i] = 1'b0;
        else if (freeze) status_d[i] = status_q[i];
        else             status_d[i] = level[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end
endmodule

// File: rtl/spi_irq_mask_ctl.sv
module spi_irq_mask_ctl
  import spi_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     set_en,
  input  logic     clr_en,
  input  irq_vec_t bits,
  output irq_vec_t mask_q,
  output irq_vec_t mask_d
);
  always_comb begin
    mask_d = mask_q;
    if (set_en) mask_d = mask_d | bits;
    if (clr_en) mask_d = mask_d & ~bits;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end
endmodule

// File: rtl/spi_irq_status_unit.sv
module spi_irq_status_unit
  import spi_irq_pkg::*;
#(
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [SEL_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic              tx_full,
  input  logic              rx_full,
  input  logic              ev_tx_underflow,
  input  logic              ev_rx_overflow,
  input  logic              ev_mode_fail,
  input  logic              lin_mode,
  output logic              irq
);
  localparam logic [CNT_W-1:0] THR_RST = CNT_W'(1);
  localparam int unsigned      PAD_ST  = DATA_W - NUM_BITS;
  localparam int unsigned      PAD_TH  = DATA_W - CNT_W;

  irq_vec_t         level, events, clr, wbits;
  irq_vec_t         status_q, status_d, mask_q, mask_d;
  logic [CNT_W-1:0] tx_thr_q, rx_thr_q;
  logic             wr_status, rd_status, wr_set, wr_clr, wr_txt, wr_rxt;
  logic             wdata_unused;

  assign wdata_unused = ^reg_wdata;
  assign wbits        = reg_wdata[NUM_BITS-1:0];

  assign wr_status = reg_wr && (reg_addr == SEL_STATUS);
  assign rd_status = reg_rd && (reg_addr == SEL_STATUS);
  assign wr_set    = reg_wr && (reg_addr == SEL_SET_EN);
  assign wr_clr    = reg_wr && (reg_addr == SEL_CLR_EN);
  assign wr_txt    = reg_wr && (reg_addr == SEL_TX_THR);
  assign wr_rxt    = reg_wr && (reg_addr == SEL_RX_THR);

  always_comb begin
    clr = '0;
    if (wr_status) clr = clr | wbits;
    if (rd_status) clr = '1;
  end

  always_comb begin
    events                = '0;
    events[BIT_TX_UNDER]  = ev_tx_underflow;
    events[BIT_MODE_FAIL] = ev_mode_fail;
    events[BIT_RX_OVER]   = ev_rx_overflow;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_thr_q <= THR_RST;
      rx_thr_q <= THR_RST;
    end else begin
      if (wr_txt) tx_thr_q <= reg_wdata[CNT_W-1:0];
      if (wr_rxt) rx_thr_q <= reg_wdata[CNT_W-1:0];
    end
  end

  spi_irq_level_eval #(.CNT_W(CNT_W)) u_level (
    .tx_count (tx_count),
    .rx_count (rx_count),
    .tx_full  (tx_full),
    .rx_full  (rx_full),
    .tx_thr   (tx_thr_q),
    .rx_thr   (rx_thr_q),
    .level    (level)
  );

  spi_irq_status_bank u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .freeze   (lin_mode),
    .level    (level),
    .events   (events),
    .clr      (clr),
    .status_q (status_q),
    .status_d (status_d)
  );

  spi_irq_mask_ctl u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (wr_set),
    .clr_en (wr_clr),
    .bits   (wbits),
    .mask_q (mask_q),
    .mask_d (mask_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         irq <= 1'b0;
    else if (!lin_mode) irq <= |(mask_d & status_d);
  end

  always_comb begin
    case (reg_sel_e'(reg_addr))
      SEL_STATUS: reg_rdata = {{PAD_ST{1'b0}}, status_q};
      SEL_MASK:   reg_rdata = {{PAD_ST{1'b0}}, mask_q};
      SEL_TX_THR: reg_rdata = {{PAD_TH{1'b0}}, tx_thr_q};
      SEL_RX_THR: reg_rdata = {{PAD_TH{1'b0}}, rx_thr_q};
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_irq_status_chk.sv
module spi_irq_status_chk
  import spi_irq_pkg::*;
#(
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [SEL_W-1:0]  reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [CNT_W-1:0]  rx_count,
  input logic [CNT_W-1:0]  rx_thr,
  input logic              ev_rx_overflow,
  input logic              lin_mode,
  input irq_vec_t          status,
  input irq_vec_t          mask,
  input logic              irq
);
  logic armed;
  logic st_touch;

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assign st_touch = (reg_wr || reg_rd) && (reg_addr == SEL_STATUS);

  a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!lin_mode && ev_rx_overflow) |=> status[BIT_RX_OVER]);

  a_r4_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (status[BIT_TX_UNDER] && !st_touch) |=> status[BIT_TX_UNDER]);

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == SEL_STATUS && lin_mode) |=> (status == '0));

  a_r7_mask_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == SEL_MASK) |=> $stable(mask));

  a_r7_enable_or: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == SEL_SET_EN)
      |=> ((mask & $past(reg_wdata[NUM_BITS-1:0])) == $past(reg_wdata[NUM_BITS-1:0])));

  a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(lin_mode)) |-> (irq == |(mask & status)));

  a_r9_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (lin_mode && !st_touch) |=> ($stable(status) && $stable(irq)));

  a_r3_rx_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!lin_mode && !st_touch)
      |=> (status[BIT_RX_LVL] == ($past(rx_count) >= $past(rx_thr))));
endmodule

bind spi_irq_status_unit spi_irq_status_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .reg_wr         (reg_wr),
  .reg_rd         (reg_rd),
  .reg_addr       (reg_addr),
  .reg_wdata      (reg_wdata),
  .rx_count       (rx_count),
  .rx_thr         (rx_thr_q),
  .ev_rx_overflow (ev_rx_overflow),
  .lin_mode       (lin_mode),
  .status         (status_q),
  .mask           (mask_q),
  .irq            (irq)
);

// File: tb/sim_spi_irq_status_unit.sv
module sim_spi_irq_status_unit;
  localparam int unsigned CNT_W  = 4;
  localparam int unsigned DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]        reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic [CNT_W-1:0]  tx_count = '0, rx_count = '0;
  logic              tx_full = 1'b0, rx_full = 1'b0;
  logic              ev_tx_underflow = 1'b0, ev_rx_overflow = 1'b0, ev_mode_fail = 1'b0;
  logic              lin_mode = 1'b0;
  logic              irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  spi_irq_status_unit #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_count(tx_count), .rx_count(rx_count), .tx_full(tx_full), .rx_full(rx_full),
    .ev_tx_underflow(ev_tx_underflow), .ev_rx_overflow(ev_rx_overflow),
    .ev_mode_fail(ev_mode_fail), .lin_mode(lin_mode), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // view a word without consuming it; called at a falling edge
  task automatic peek(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_consume(output logic [31:0] v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 3'd0;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    peek(3'd0, v); chk("R1 status", v, 32'h0);
    peek(3'd3, v); chk("R1 mask", v, 32'h0);
    peek(3'd4, v); chk("R1 tx thr", v, 32'h1);
    peek(3'd5, v); chk("R1 rx thr", v, 32'h1);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_levels();
    logic [31:0] v;
    rst_n = 1'b1;
    step();
    peek(3'd0, v); chk("R2 idle tx low", v, 32'h04);
    rx_count = 4'd1;
    #1 peek(3'd0, v); chk("R2 latency before edge", v, 32'h04);
    step();
    peek(3'd0, v); chk("R2 rx level after edge", v, 32'h14);
    rx_count = 4'd0; tx_count = 4'd1; rx_full = 1'b1; tx_full = 1'b1;
    step();
    peek(3'd0, v); chk("R2 full flags", v, 32'h28);
    rx_full = 1'b0; tx_full = 1'b0; tx_count = 4'd0;
    step();
    peek(3'd0, v); chk("R2 back to idle", v, 32'h04);
  endtask

  task automatic t_thresholds();
    logic [31:0] v;
    wr(3'd5, 32'd3);
    wr(3'd4, 32'd4);
    peek(3'd5, v); chk("R11 rx thr readback", v, 32'd3);
    peek(3'd4, v); chk("R11 tx thr readback", v, 32'd4);
    rx_count = 4'd2; tx_count = 4'd4; step();
    peek(3'd0, v); chk("R3 rx below, tx at thr", v, 32'h00);
    rx_count = 4'd3; tx_count = 4'd3; step();
    peek(3'd0, v); chk("R3 rx at thr, tx below", v, 32'h14);
    rx_count = 4'd0; tx_count = 4'd0;
    wr(3'd5, 32'd1);
    wr(3'd4, 32'd1);
    step();
    peek(3'd0, v); chk("R11 restored", v, 32'h04);
  endtask

  task automatic t_sticky();
    logic [31:0] v;
    @(negedge clk); ev_tx_underflow = 1'b1;
    @(negedge clk); ev_tx_underflow = 1'b0;
    step(); step(); step();
    peek(3'd0, v); chk("R4 underflow held", v, 32'h44);
    wr(3'd0, 32'h40);
    peek(3'd0, v); chk("R6 w1c underflow", v, 32'h04);
    @(negedge clk); ev_rx_overflow = 1'b1; ev_mode_fail = 1'b1;
    @(negedge clk); ev_rx_overflow = 1'b0; ev_mode_fail = 1'b0;
    wr(3'd0, 32'h02);
    peek(3'd0, v); chk("R6 w1c leaves others", v, 32'h05);
    @(negedge clk); ev_mode_fail = 1'b1;
    @(negedge clk); ev_mode_fail = 1'b0;
    rd_consume(v); chk("R5 read value", v, 32'h07);
    peek(3'd0, v); chk("R5 cleared after read", v, 32'h00);
    step();
    peek(3'd0, v); chk("R5 level back", v, 32'h04);
  endtask

  task automatic t_mask_irq();
    logic [31:0] v;
    wr(3'd1, 32'h04);
    chk("R8 irq on enable", {31'b0, irq}, 32'h1);
    peek(3'd3, v); chk("R7 mask after set", v, 32'h04);
    peek(3'd1, v); chk("R7 set reg reads 0", v, 32'h0);
    wr(3'd2, 32'h04);
    chk("R8 irq off on disable", {31'b0, irq}, 32'h0);
    wr(3'd1, 32'h41);
    chk("R8 irq masked status", {31'b0, irq}, 32'h0);
    @(negedge clk); ev_tx_underflow = 1'b1;
    @(negedge clk); ev_tx_underflow = 1'b0;
    chk("R8 irq on event", {31'b0, irq}, 32'h1);
    wr(3'd3, 32'h0);
    peek(3'd3, v); chk("R7 mask write ignored", v, 32'h41);
    chk("R7 irq kept", {31'b0, irq}, 32'h1);
    wr(3'd0, 32'h40);
    chk("R8 irq cleared", {31'b0, irq}, 32'h0);
    wr(3'd2, 32'h41);
    peek(3'd3, v); chk("R7 mask cleared", v, 32'h0);
  endtask

  task automatic t_event_wins();
    logic [31:0] v;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h01; ev_rx_overflow = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; ev_rx_overflow = 1'b0;
    peek(3'd0, v); chk("R10 event beats w1c", v, 32'h05);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 3'd0; ev_mode_fail = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0; ev_mode_fail = 1'b0;
    peek(3'd0, v); chk("R10 event beats read clear", v, 32'h02);
    wr(3'd0, 32'h02);
    peek(3'd0, v); chk("R6 w1c sticky only", v, 32'h04);
  endtask

  task automatic t_freeze();
    logic [31:0] v;
    wr(3'd1, 32'h10);
    @(negedge clk); lin_mode = 1'b1; rx_count = 4'd5;
    @(negedge clk);
    peek(3'd0, v); chk("R9 level frozen", v, 32'h04);
    chk("R9 irq held", {31'b0, irq}, 32'h0);
    ev_tx_underflow = 1'b1;
    @(negedge clk); ev_tx_underflow = 1'b0;
    peek(3'd0, v); chk("R9 event ignored", v, 32'h04);
    rd_consume(v); chk("R9 read while frozen", v, 32'h04);
    step();
    peek(3'd0, v); chk("R9 clear stays while frozen", v, 32'h00);
    @(negedge clk); lin_mode = 1'b0;
    @(negedge clk);
    peek(3'd0, v); chk("R9 resume recompute", v, 32'h14);
    chk("R8 irq after resume", {31'b0, irq}, 32'h1);
    rx_count = 4'd0;
    wr(3'd2, 32'h10);
    chk("R8 irq off", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_levels();
    t_thresholds();
    t_sticky();
    t_mask_irq();
    t_event_wins();
    t_freeze();
    step();
    finish_run();
  end
endmodule